// File: doc/BRIEF.md
# Programmable Receive Frame Filter

This block decides, for each received Ethernet frame, whether the frame is kept or discarded and which DMA channel a kept frame goes to. Bytes enter on a plain byte stream with start and end markers. The first bytes of each frame are packed into a small buffer of 32-bit words. After the end marker, a walker steps through a rule table that another block writes. Each rule compares one masked word of the frame against a reference value. Depending on the result, the rule settles the verdict, hands control to a later rule, or lets the walk fall through to the next rule.

A rule is four 32-bit table words. Word 0 is the reference value and word 1 is the compare mask. Word 2 holds the control fields. Word 3 is reserved. A compare that straddles a word boundary is built from two rules: the first links forward to the second. The last rule in use is normally a catch-all that keeps any frame no earlier rule decided. Table depth and inspectable header length are parameters.

Top module: `frame_match_filter`

## Requirements
- R1: Frame byte k (counting from 0 at the start marker) is stored in captured word k/4, bits 8*(k%4)+7 down to 8*(k%4). Bytes at or beyond MAX_OFF are not stored. A rule's word offset (control bits 15:8) selects captured word number offset.
- R2: A rule hits when (captured word AND mask) equals (reference AND mask). Reference is table word 0 of the rule; mask is table word 1.
- R3: When the inverse bit (control bit 2) is set, the result of the compare in R2 is inverted.
- R4: A hit on a rule with the link bit (control bit 3) set continues the walk at the rule given by control bits 23:16. If that target is not greater than the current rule, the frame is dropped.
- R5: A hit on a rule without the link bit ends the walk. If the keep bit (control bit 0) is set, the frame is accepted on the channel in control bits 31:24. Otherwise it is dropped, which includes the case where only the discard bit (control bit 1) is set. A drop always reports channel 0.
- R6: A miss moves the walk to the next rule. A walk that reaches a rule index at or beyond the smaller of the valid-rule count, the parsable-rule count and DEPTH drops the frame.
- R7: A rule whose word is not completely captured cannot hit, whatever its inverse bit says. This covers a frame that ended too early and an offset at or beyond MAX_OFF/4.
- R8: A rule with a zero mask, the keep bit set and offset 0 accepts every frame of at least four bytes that reaches it.
- R9: While the parser enable is low, every frame end gives an accept verdict on channel 0 in the cycle after the end byte. `parserIdle` is high exactly when the enable is low and no walk is in progress.
- R10: With the enable high, the walk starts in the cycle after the end byte and examines one rule per clock. `verdictValid` pulses for one cycle in the cycle after the deciding rule or the out-of-range step, so the latency in cycles equals the number of walk steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| parserEn | input | 1 | Parser enable |
| parserIdle | output | 1 | High when disabled and no walk is running |
| validCount | input | 8 | Number of valid rules |
| parsableCount | input | 8 | Number of rules the walker may visit |
| tblWrEn | input | 1 | Table word write strobe |
| tblWrAddr | input | log2(DEPTH*4) | Rule index in the upper bits, word number in the low two bits |
| tblWrData | input | 32 | Table word to write |
| inValid | input | 1 | Byte strobe |
| inSof | input | 1 | First byte of frame |
| inEof | input | 1 | Last byte of frame |
| inData | input | 8 | Frame byte |
| verdictValid | output | 1 | One-cycle verdict pulse |
| verdictAccept | output | 1 | 1 keeps the frame, 0 drops it |
| verdictChan | output | 8 | DMA channel of a kept frame |

## Verification
The bench aims at the walk's control corners and compares each verdict and its latency against an independent model of the rules. A design with a broken link would land a chained compare on the wrong rule or loop on a backward target. A design that mishandled absent words would let an inverted compare hit on a short frame, or would read beyond the capture buffer. A design that used only one of the two rule counts as the limit would walk into stale rules. A design that ignored the disabled state would evaluate frames instead of passing them. Long frames check that bytes past the capture window leave the captured words intact.

// File: rtl/ffilt_pkg.sv
package ffilt_pkg;

  typedef enum logic {ST_IDLE, ST_EVAL} walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       capEn;
    logic       capRestart;
    logic [7:0] entryIdx;
  } ctrlStrobe_t;

  // decoded control word of one rule
  typedef struct packed {
    logic [7:0] chan;
    logic [7:0] jump;
    logic [7:0] wordOff;
    logic [3:0] rsvd;
    logic       nextChk;
    logic       invMatch;
    logic       rejectF;
    logic       acceptF;
  } entryCtl_t;

endpackage

// File: rtl/ffilt_datapath.sv
module ffilt_datapath
  import ffilt_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MAX_OFF = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tblWrEn,
  input  logic [$clog2(DEPTH*4)-1:0]   tblWrAddr,
  input  logic [31:0]                  tblWrData,
  input  logic [7:0]                   inData,
  input  ctrlStrobe_t                  strobe,
  output entryCtl_t                    entCtl,
  output logic                         wordHit
);
  localparam int CAP_WORDS = MAX_OFF / 4;
  localparam int CNT_W     = $clog2(MAX_OFF + 1);
  localparam int IDX_W     = $clog2(DEPTH);
  localparam int CW_W      = $clog2(CAP_WORDS);

  // rule table, written by the configuration side
  logic [31:0] tblMem [DEPTH*4];

  always_ff @(posedge clk) begin
    if (tblWrEn) tblMem[tblWrAddr] <= tblWrData;
  end

  // frame capture
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] wrPos;
  logic             wrOk;
  logic [31:0]      capWord [CAP_WORDS];

  assign wrPos = strobe.capRestart ? '0 : byteCnt;
  assign wrOk  = strobe.capEn && (strobe.capRestart || (byteCnt < CNT_W'(MAX_OFF)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (strobe.capEn) begin
      if (strobe.capRestart)                byteCnt <= CNT_W'(1);
      else if (byteCnt < CNT_W'(MAX_OFF))   byteCnt <= byteCnt + 1'b1;
    end
  end

  for (genvar w = 0; w < CAP_WORDS; w++) begin : gCap
    logic [31:0] wordReg;
    always_ff @(posedge clk) begin
      if (wrOk && (wrPos[CNT_W-1:2] == (CNT_W-2)'(w)))
        wordReg[{wrPos[1:0], 3'b000} +: 8] <= inData;
    end
    assign capWord[w] = wordReg;
  end

  // rule read and compare
  logic [IDX_W-1:0] rdIdx;
  logic [31:0]      refData, cmpMask, selWord;
  logic [9:0]       needBytes;
  logic             wordPresent, wordEq;

  assign rdIdx   = strobe.entryIdx[IDX_W-1:0];
  assign refData = tblMem[{rdIdx, 2'd0}];
  assign cmpMask = tblMem[{rdIdx, 2'd1}];
  assign entCtl  = entryCtl_t'(tblMem[{rdIdx, 2'd2}]);

  assign needBytes   = {entCtl.wordOff, 2'b00} + 10'd4;
  assign wordPresent = (entCtl.wordOff < 8'(CAP_WORDS)) && (10'(byteCnt) >= needBytes);
  assign selWord     = capWord[entCtl.wordOff[CW_W-1:0]];
  assign wordEq      = ((selWord ^ refData) & cmpMask) == 32'd0;
  assign wordHit     = wordPresent && (wordEq ^ entCtl.invMatch);

  // capture counter never runs past the window (R1)
  assert_capture_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CNT_W'(MAX_OFF));

  // a restart byte always leaves exactly one byte counted (R1)
  assert_restart_count_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capEn && strobe.capRestart) |=> byteCnt == CNT_W'(1));

endmodule

// File: rtl/ffilt_control.sv
module ffilt_control
  import ffilt_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        parserEn,
  input  logic [7:0]  validCount,
  input  logic [7:0]  parsableCount,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        inEof,
  input  entryCtl_t   entCtl,
  input  logic        wordHit,
  output ctrlStrobe_t strobe,
  output logic        verdictValid,
  output logic        verdictAccept,
  output logic [7:0]  verdictChan,
  output logic        parserIdle
);
  walkState_t state;
  logic [8:0] curIdx;
  logic [8:0] limit;
  logic       idxOut;

  always_comb begin
    limit = {1'b0, validCount};
    if ({1'b0, parsableCount} < limit) limit = {1'b0, parsableCount};
    if (9'(DEPTH) < limit)             limit = 9'(DEPTH);
  end

  assign idxOut = curIdx >= limit;

  assign strobe.capEn      = inValid && (state == ST_IDLE);
  assign strobe.capRestart = inSof;
  assign strobe.entryIdx   = curIdx[7:0];
  assign parserIdle        = !parserEn && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      curIdx        <= '0;
      verdictValid  <= 1'b0;
      verdictAccept <= 1'b0;
      verdictChan   <= '0;
    end else begin
      verdictValid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (inValid && inEof) begin
            if (parserEn) begin
              state  <= ST_EVAL;
              curIdx <= '0;
            end else begin
              verdictValid  <= 1'b1;
              verdictAccept <= 1'b1;
              verdictChan   <= '0;
            end
          end
        end
        ST_EVAL: begin
          if (idxOut) begin
            verdictValid  <= 1'b1;
            verdictAccept <= 1'b0;
            verdictChan   <= '0;
            state         <= ST_IDLE;
          end else if (wordHit && entCtl.nextChk) begin
            if ({1'b0, entCtl.jump} <= curIdx) begin
              verdictValid  <= 1'b1;
              verdictAccept <= 1'b0;
              verdictChan   <= '0;
              state         <= ST_IDLE;
            end else begin
              curIdx <= {1'b0, entCtl.jump};
            end
          end else if (wordHit) begin
            verdictValid  <= 1'b1;
            verdictAccept <= entCtl.acceptF;
            verdictChan   <= entCtl.acceptF ? entCtl.chan : 8'd0;
            state         <= ST_IDLE;
          end else begin
            curIdx <= curIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // the walk only moves forward (R4, R6)
  assert_forward_walk_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVAL && $past(state) == ST_EVAL) |-> curIdx > $past(curIdx));

  // a drop carries no channel (R5)
  assert_drop_chan_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && !verdictAccept) |-> verdictChan == 8'd0);

  // disabled parser passes the frame in the next cycle (R9)
  assert_bypass_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inEof && !parserEn && state == ST_IDLE) |=> (verdictValid && verdictAccept));

  // a verdict comes only from a walk step or a bypassed frame end (R10)
  assert_verdict_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |-> ($past(state) == ST_EVAL || $past(inValid && inEof && !parserEn)));

endmodule

// File: rtl/frame_match_filter.sv
module frame_match_filter
  import ffilt_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MAX_OFF = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       parserEn,
  output logic                       parserIdle,
  input  logic [7:0]                 validCount,
  input  logic [7:0]                 parsableCount,
  input  logic                       tblWrEn,
  input  logic [$clog2(DEPTH*4)-1:0] tblWrAddr,
  input  logic [31:0]                tblWrData,
  input  logic                       inValid,
  input  logic                       inSof,
  input  logic                       inEof,
  input  logic [7:0]                 inData,
  output logic                       verdictValid,
  output logic                       verdictAccept,
  output logic [7:0]                 verdictChan
);
  ctrlStrobe_t strobe;
  entryCtl_t   entCtl;
  logic        wordHit;

  ffilt_datapath #(.DEPTH(DEPTH), .MAX_OFF(MAX_OFF)) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .tblWrEn   (tblWrEn),
    .tblWrAddr (tblWrAddr),
    .tblWrData (tblWrData),
    .inData    (inData),
    .strobe    (strobe),
    .entCtl    (entCtl),
    .wordHit   (wordHit)
  );

  ffilt_control #(.DEPTH(DEPTH)) uControl (
    .clk           (clk),
    .rstN          (rstN),
    .parserEn      (parserEn),
    .validCount    (validCount),
    .parsableCount (parsableCount),
    .inValid       (inValid),
    .inSof         (inSof),
    .inEof         (inEof),
    .entCtl        (entCtl),
    .wordHit       (wordHit),
    .strobe        (strobe),
    .verdictValid  (verdictValid),
    .verdictAccept (verdictAccept),
    .verdictChan   (verdictChan),
    .parserIdle    (parserIdle)
  );

endmodule

// File: tb/tb_frame_match_filter.sv
module tb_frame_match_filter;
  localparam int CLK_P   = 10;
  localparam int DEPTH   = 64;
  localparam int MAX_OFF = 64;
  localparam int AW      = $clog2(DEPTH*4);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        parserEn = 1'b0;
  logic        parserIdle;
  logic [7:0]  validCount = 8'd0, parsableCount = 8'd0;
  logic        tblWrEn = 1'b0;
  logic [AW-1:0] tblWrAddr = '0;
  logic [31:0] tblWrData = '0;
  logic        inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0]  inData = 8'd0;
  logic        verdictValid, verdictAccept;
  logic [7:0]  verdictChan;

  always #(CLK_P/2) clk = ~clk;

  frame_match_filter #(.DEPTH(DEPTH), .MAX_OFF(MAX_OFF)) dut (
    .clk(clk), .rstN(rstN), .parserEn(parserEn), .parserIdle(parserIdle),
    .validCount(validCount), .parsableCount(parsableCount),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .inValid(inValid), .inSof(inSof), .inEof(inEof), .inData(inData),
    .verdictValid(verdictValid), .verdictAccept(verdictAccept), .verdictChan(verdictChan)
  );

  typedef struct {
    bit       acc;
    bit [7:0] chan;
    int       lat;
    string    tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0, errors = 0;
  int cyc = 0, eofCyc = 0;
  bit done = 1'b0;

  logic [31:0] sData [DEPTH];
  logic [31:0] sMask [DEPTH];
  logic [31:0] sCtl  [DEPTH];
  logic [7:0]  fb [80];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mkCtl(bit af, bit rf, bit im, bit nc,
                                        logic [7:0] off, logic [7:0] jump, logic [7:0] chan);
    return {chan, jump, off, 4'b0, nc, im, rf, af};
  endfunction

  task automatic writeEntry(int idx, logic [31:0] d, logic [31:0] m, logic [31:0] c);
    logic [31:0] words [3];
    words[0] = d; words[1] = m; words[2] = c;
    sData[idx] = d; sMask[idx] = m; sCtl[idx] = c;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      tblWrEn   = 1'b1;
      tblWrAddr = AW'(idx * 4 + k);
      tblWrData = words[k];
    end
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  // reference walk built from the requirements
  task automatic model(int len, output bit acc, output bit [7:0] ch, output int lat);
    int idx = 0;
    int lim = (validCount < parsableCount) ? int'(validCount) : int'(parsableCount);
    int capLen = (len > MAX_OFF) ? MAX_OFF : len;
    if (lim > DEPTH) lim = DEPTH;
    acc = 1'b0; ch = 8'd0; lat = 0;
    if (!parserEn) begin acc = 1'b1; return; end
    for (int step = 0; step < 600; step++) begin
      int off;
      bit present, eq, hit;
      logic [31:0] word;
      logic [31:0] c;
      lat++;
      if (idx >= lim) begin acc = 1'b0; ch = 8'd0; return; end
      c = sCtl[idx];
      off = int'(c[15:8]);
      present = (off < MAX_OFF/4) && (capLen >= 4*off + 4);
      word = present ? {fb[4*off+3], fb[4*off+2], fb[4*off+1], fb[4*off]} : 32'd0;
      eq  = ((word ^ sData[idx]) & sMask[idx]) == 32'd0;
      hit = present && (eq != c[2]);
      if (hit && c[3]) begin
        if (int'(c[23:16]) <= idx) begin acc = 1'b0; ch = 8'd0; return; end
        idx = int'(c[23:16]);
      end else if (hit) begin
        acc = c[0];
        ch  = c[0] ? c[31:24] : 8'd0;
        return;
      end else begin
        idx++;
      end
    end
  endtask

  task automatic clearFrame();
    for (int i = 0; i < 80; i++) fb[i] = 8'd0;
  endtask

  task automatic sendFrame(int len, string tag);
    exp_t e;
    bit got;
    model(len, e.acc, e.chan, e.lat);
    e.tag = tag;
    expQ.push_back(e);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = fb[i];
      inSof   = (i == 0);
      inEof   = (i == len - 1);
      if (i == len - 1) eofCyc = cyc + 1;
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    got = 1'b0;
    for (int w = 0; w < 400; w++) begin
      @(posedge clk);
      if (expQ.size() == 0) begin got = 1'b1; break; end
    end
    if (!got) begin
      checks++; errors++;
      $display("FAIL %s: no verdict (actual none, expected accept=%0d chan=%0d)", tag, e.acc, e.chan);
      expQ.delete();
    end
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && verdictValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected verdict (actual accept=%0d chan=%0d, expected none)",
                 verdictAccept, verdictChan);
      end else begin
        exp_t e;
        int lat;
        e = expQ.pop_front();
        lat = cyc - eofCyc;
        if (verdictAccept !== e.acc || verdictChan !== e.chan || lat != e.lat) begin
          errors++;
          $display("FAIL %s: actual accept=%0d chan=%0d lat=%0d, expected accept=%0d chan=%0d lat=%0d",
                   e.tag, verdictAccept, verdictChan, lat, e.acc, e.chan, e.lat);
        end
      end
    end
  end

  task automatic checkIdle(bit exp, string tag);
    checks++;
    if (parserIdle !== exp) begin
      errors++;
      $display("FAIL %s: parserIdle actual=%0d expected=%0d", tag, parserIdle, exp);
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10: watchdog expired (actual hang, expected completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    checks++;
    if (verdictValid !== 1'b0) begin
      errors++;
      $display("FAIL R10: verdictValid after reset actual=%0d expected=0", verdictValid);
    end
    checkIdle(1'b1, "R9 idle while disabled after reset");

    // rule table
    writeEntry(0, 32'hDEADBEEF, 32'hFFFFFFFF, mkCtl(0,1,0,0, 8'd1, 8'd0, 8'd0));
    writeEntry(1, 32'hAB000000, 32'hFFFF0000, mkCtl(1,0,0,0, 8'd3, 8'd0, 8'd5));
    writeEntry(2, 32'h00003300, 32'h0000FF00, mkCtl(0,0,0,1, 8'd2, 8'd4, 8'd0));
    writeEntry(3, 32'h00000077, 32'h000000FF, mkCtl(1,0,0,0, 8'd0, 8'd0, 8'd9));
    writeEntry(4, 32'h00000044, 32'h000000FF, mkCtl(1,0,0,0, 8'd3, 8'd0, 8'd3));
    writeEntry(5, 32'h00000000, 32'hFFFFFFFF, mkCtl(1,0,1,0, 8'd4, 8'd0, 8'd6));
    writeEntry(6, 32'h00000000, 32'h00000000, mkCtl(1,0,0,0, 8'd20, 8'd0, 8'd1));
    writeEntry(7, 32'h00000000, 32'h00000000, mkCtl(1,0,0,0, 8'd0, 8'd0, 8'd0));
    validCount = 8'd8; parsableCount = 8'd8;
    parserEn = 1'b1;
    @(negedge clk);
    checkIdle(1'b0, "R9 not idle while enabled");

    clearFrame(); fb[4] = 8'hEF; fb[5] = 8'hBE; fb[6] = 8'hAD; fb[7] = 8'hDE;
    sendFrame(20, "R5 discard rule, R1 byte lanes");
    clearFrame(); fb[14] = 8'h00; fb[15] = 8'hAB;
    sendFrame(20, "R2 masked upper half compare");
    clearFrame(); fb[9] = 8'h33; fb[12] = 8'h44;
    sendFrame(20, "R4 linked pair hit");
    clearFrame(); fb[9] = 8'h33; fb[12] = 8'h45; fb[17] = 8'h01;
    sendFrame(20, "R3 linked miss then inverse hit");
    clearFrame(); fb[0] = 8'h77;
    sendFrame(20, "R6 miss advances to next rule");
    clearFrame();
    sendFrame(20, "R8 catch-all after inverse miss, R7 offset beyond window");
    clearFrame(); for (int i = 0; i < 16; i++) fb[i] = 8'(i + 1);
    sendFrame(16, "R7 absent word blocks inverse");
    clearFrame(); fb[0] = 8'h77;
    sendFrame(2, "R7 short frame falls off table");
    clearFrame(); for (int i = 64; i < 80; i++) fb[i] = 8'hFF;
    sendFrame(72, "R1 bytes past window ignored");

    parsableCount = 8'd3;
    clearFrame();
    sendFrame(20, "R6 parsable count bound");
    parsableCount = 8'd8; validCount = 8'd2;
    clearFrame();
    sendFrame(20, "R6 valid count bound");
    validCount = 8'd8;

    writeEntry(7, 32'h00000000, 32'h00000000, mkCtl(0,0,0,1, 8'd0, 8'd2, 8'd0));
    clearFrame();
    sendFrame(20, "R4 backward link drops");

    parserEn = 1'b0;
    @(negedge clk);
    checkIdle(1'b1, "R9 idle once disabled");
    clearFrame(); fb[4] = 8'hEF; fb[5] = 8'hBE; fb[6] = 8'hAD; fb[7] = 8'hDE;
    sendFrame(20, "R9 bypass accept while disabled");

    parserEn = 1'b1;
    writeEntry(7, 32'h00000000, 32'h00000000, mkCtl(1,0,0,0, 8'd0, 8'd0, 8'd12));
    clearFrame(); fb[1] = 8'h5A;
    sendFrame(8, "R8 catch-all channel, R10 latency");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule